// File: doc/BRIEF.md
# Compare-Action Timer/Counter

A 16-bit counter advances on a selectable count tick and is compared with a 16-bit compare register on every step. Two events come out of that datapath: a compare hit, when the count equals the compare value, and a wrap, when the count reaches the wrap ceiling. The ceiling is chosen by a mode field. It is either the full 16-bit scale or one of three fixed smaller ceilings. A control byte holds a separate action bit for each event. The action bits decide whether the event clears the counter, flips the output, or latches an interrupt flag. With these bits, one datapath covers free-running counting, periodic tick generation, square-wave output and wrap detection.

The count tick comes from the system clock or from one of seven external tick inputs. Each external input is resynchronised and edge-detected into a single-cycle step. The flipped output appears on one of two output pins, and the other pin is held low. Software reaches the block through a byte-wide bus. The 16-bit compare and counter registers move through a shared high-byte holding latch, so every 16-bit transfer is atomic.

Top module: `cmpact_timer`

## Requirements
- R1: With the hit-clear action (control bit 0, address 0) and hit-flip action (control bit 1) set, a compare value y makes the counter run 0..y and the routed output flip once every y+1 steps.
- R2: The wrap ceiling is chosen by mode bits [1:0] (address 1): 0 selects 0xFFFF, 1 selects 0x00FF, 2 selects 0x01FF and 3 selects 0x03FF. One step taken at the ceiling returns the counter to 0. If the wrap-flag action (control bit 4) is set, that step also sets flag bit 1 (address 2).
- R3: A compare hit with the hit-flag action (control bit 2) set sets flag bit 0. Writing a one to a flag bit clears it, and writing a zero leaves it unchanged.
- R4: The irq output is high exactly when some flag bit is set and its mask bit (address 3, same bit position) is set.
- R5: Mode bit 5 routes the flip state to out_b when 1 and to out_a when 0. The pin not selected stays low.
- R6: Writing the compare high byte (address 5) only loads the holding latch. Writing the low byte (address 4) commits both bytes at once. The counter follows the same rule: high byte at address 7, low byte at address 6.
- R7: Reading a low byte (address 4 or 6) copies the matching high byte into the holding latch. A following read of the high byte returns that copy, even if the counter has moved since.
- R8: Mode bits [4:2] pick the tick source. Source 0 is every system clock. Source k (k from 1 to 7) is each rising edge of ext_tick[k-1]. Edges on inputs not selected leave the counter unchanged. Mode bit 6 must be set for any counting to happen.
- R9: With hit-clear off, a compare hit does not disturb counting, and the counter passes through the compare value.
- R10: After reset, every register reads 0, both pins are low and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 7 | External tick inputs for sources 1..7 |
| reg_addr | input | 3 | Byte register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (drives the high-byte capture) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| out_a | output | 1 | Flip output, pin A |
| out_b | output | 1 | Flip output, pin B |
| irq | output | 1 | Masked interrupt request |

## Verification
A register write takes effect at the next clock edge. The bench therefore reads back or observes outputs only at the falling edge that follows, and reg_rdata is sampled within the same low phase in which the address is driven. An external tick edge reaches the counter three clock edges after it is driven: two synchroniser stages plus the counter register. Each pulse is held high for two cycles and low for two, and the bench waits a further three cycles before reading. Output flips are timed by counting falling edges between two changes of the pin, so the y+1 period check needs no fixed start latency.

// File: rtl/cmpact_timer_pkg.sv
package cmpact_timer_pkg;

   localparam int BYTE_W   = 8;
   localparam int CEIL_LOG = 8;   // smallest fixed ceiling is 2**CEIL_LOG - 1

   typedef enum logic [2:0] {
      A_CTRL = 3'd0,
      A_MODE = 3'd1,
      A_FLAG = 3'd2,
      A_IMSK = 3'd3,
      A_CMPL = 3'd4,
      A_CMPH = 3'd5,
      A_CNTL = 3'd6,
      A_CNTH = 3'd7
   } addr_e;

   typedef struct packed {
      logic [2:0] spare;
      logic       wrap_flag;
      logic       wrap_flip;
      logic       hit_flag;
      logic       hit_flip;
      logic       hit_clear;
   } ctl_t;

   typedef struct packed {
      logic       spare;
      logic       run;
      logic       pin_b;
      logic [2:0] src;
      logic [1:0] ceil;
   } mode_t;

   function automatic logic [15:0] ceil_value(input logic [1:0] sel);
      if (sel == 2'd0) return 16'hFFFF;
      return 16'((32'd1 << (32'(sel) + CEIL_LOG - 1)) - 32'd1);
   endfunction

endpackage

// File: rtl/cmpact_tick_sel.sv
module cmpact_tick_sel #(
   parameter int N_SRC       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int SRC_W      = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src,
   input  logic [N_SRC-2:0] ext_tick,
   output logic             tick
);

   logic [N_SRC-1:0] pulses;

   assign pulses[0] = 1'b1;

   for (genvar g = 1; g < N_SRC; g++) begin : g_src
      logic [SYNC_STAGES:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[SYNC_STAGES-1:0], ext_tick[g-1]};
      end
      assign pulses[g] = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
   end

   assign tick = pulses[src];

endmodule

// File: rtl/cmpact_count_core.sv
module cmpact_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] ceil,
   input  logic [CNT_W-1:0] cmp,
   input  logic             hit_clear,
   input  logic             hit_flip,
   input  logic             wrap_flip,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             hit_ev,
   output logic             wrap_ev,
   output logic             flip
);

   logic at_ceil, at_cmp;
   logic [CNT_W-1:0] cnt_nx;

   assign at_ceil = (cnt == ceil);
   assign at_cmp  = (cnt == cmp);
   assign hit_ev  = step & at_cmp;
   assign wrap_ev = step & at_ceil;

   always_comb begin
      cnt_nx = cnt;
      if (load)
         cnt_nx = load_val;
      else if (step) begin
         if (at_ceil || (at_cmp && hit_clear)) cnt_nx = '0;
         else                                  cnt_nx = cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         flip <= 1'b0;
      end else begin
         cnt <= cnt_nx;
         if ((hit_ev && hit_flip) || (wrap_ev && wrap_flip)) flip <= ~flip;
      end
   end

endmodule

// File: rtl/cmpact_regs.sv
module cmpact_regs
   import cmpact_timer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int N_FLAG = 2,
   localparam int HALF  = CNT_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              hit_ev,
   input  logic              wrap_ev,
   output ctl_t              ctl,
   output mode_t             mode,
   output logic [CNT_W-1:0]  cmp,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic [N_FLAG-1:0] flags,
   output logic [N_FLAG-1:0] imsk,
   output logic              irq
);

   logic [HALF-1:0]   hold;
   logic [N_FLAG-1:0] fl_set, fl_clr;
   addr_e             a;

   assign a        = addr_e'(addr);
   assign fl_set   = {wrap_ev & ctl.wrap_flag, hit_ev & ctl.hit_flag};
   assign fl_clr   = (wr && a == A_FLAG) ? wdata[N_FLAG-1:0] : '0;
   assign load     = wr && (a == A_CNTL);
   assign load_val = {hold, wdata};
   assign irq      = |(flags & imsk);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl   <= '0;
         mode  <= '0;
         cmp   <= '0;
         hold  <= '0;
         imsk  <= '0;
         flags <= '0;
      end else begin
         flags <= (flags & ~fl_clr) | fl_set;
         if (wr) begin
            case (a)
               A_CTRL:         ctl  <= ctl_t'(wdata);
               A_MODE:         mode <= mode_t'(wdata);
               A_IMSK:         imsk <= wdata[N_FLAG-1:0];
               A_CMPL:         cmp  <= {hold, wdata};
               A_CMPH, A_CNTH: hold <= wdata;
               default: ;
            endcase
         end else if (rd) begin
            if (a == A_CMPL) hold <= cmp[CNT_W-1:HALF];
            if (a == A_CNTL) hold <= cnt[CNT_W-1:HALF];
         end
      end
   end

   always_comb begin
      case (a)
         A_CTRL:  rdata = ctl;
         A_MODE:  rdata = mode;
         A_FLAG:  rdata = BYTE_W'(flags);
         A_IMSK:  rdata = BYTE_W'(imsk);
         A_CMPL:  rdata = cmp[HALF-1:0];
         A_CNTL:  rdata = cnt[HALF-1:0];
         default: rdata = hold;
      endcase
   end

endmodule

// File: rtl/cmpact_timer.sv
module cmpact_timer
   import cmpact_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int N_SRC       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-2:0] ext_tick,
   input  logic [2:0]       reg_addr,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   output logic             out_a,
   output logic             out_b,
   output logic             irq
);

   localparam int SRC_W = $clog2(N_SRC);

   if (CNT_W != 2 * BYTE_W) begin : g_bad_width
      $error("cmpact_timer: CNT_W must be two bus bytes");
   end
   if (N_SRC < 2 || N_SRC > 8 || (1 << SRC_W) != N_SRC) begin : g_bad_src
      $error("cmpact_timer: N_SRC must be a power of two from 2 to 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cmpact_timer: SYNC_STAGES must be at least 2");
   end

   ctl_t             ctl;
   mode_t            mode;
   logic [CNT_W-1:0] cmp, cnt, load_val, ceil;
   logic             load, tick, step, hit_ev, wrap_ev, flip;
   logic [1:0]       flags, imsk;

   assign ceil = ceil_value(mode.ceil);
   assign step = tick & mode.run;

   cmpact_tick_sel #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk(clk), .rst_n(rst_n), .src(mode.src[SRC_W-1:0]),
      .ext_tick(ext_tick), .tick(tick)
   );

   cmpact_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .step(step), .ceil(ceil), .cmp(cmp),
      .hit_clear(ctl.hit_clear), .hit_flip(ctl.hit_flip),
      .wrap_flip(ctl.wrap_flip), .load(load), .load_val(load_val),
      .cnt(cnt), .hit_ev(hit_ev), .wrap_ev(wrap_ev), .flip(flip)
   );

   cmpact_regs #(.CNT_W(CNT_W), .N_FLAG(2)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
      .wdata(reg_wdata), .rdata(reg_rdata), .cnt(cnt), .hit_ev(hit_ev),
      .wrap_ev(wrap_ev), .ctl(ctl), .mode(mode), .cmp(cmp), .load(load),
      .load_val(load_val), .flags(flags), .imsk(imsk), .irq(irq)
   );

   assign out_a = flip & ~mode.pin_b;
   assign out_b = flip &  mode.pin_b;

endmodule

// File: rtl/cmpact_timer_chk.sv
module cmpact_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step,
   input logic             load,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp,
   input logic [CNT_W-1:0] ceil,
   input logic             hit_clear,
   input logic             hit_flag,
   input logic [1:0]       flags,
   input logic [1:0]       imsk,
   input logic             irq,
   input logic             flip,
   input logic             out_a,
   input logic             out_b
);

   // R1
   hit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt == cmp && hit_clear && !load) |=> (cnt == '0));

   // R2
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt == ceil && !load) |=> (cnt == '0));

   // R9
   count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt != ceil && !(cnt == cmp && hit_clear) && !load)
      |=> (cnt == $past(cnt) + 1'b1));

   // R3
   hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt == cmp && hit_flag) |=> flags[0]);

   // R4
   irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> ((flags & imsk) == 2'b00));

   // R5
   pin_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_a, out_b}));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(cnt));

   // R1
   flip_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(flip));

endmodule

bind cmpact_timer cmpact_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .step(step), .load(load), .cnt(cnt),
   .cmp(cmp), .ceil(ceil), .hit_clear(ctl.hit_clear),
   .hit_flag(ctl.hit_flag), .flags(flags), .imsk(imsk), .irq(irq),
   .flip(flip), .out_a(out_a), .out_b(out_b)
);

// File: tb/cmpact_timer_bench.sv
`timescale 1ns/1ps
module cmpact_timer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] ext_tick = '0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       out_a, out_b, irq;

   int vectors = 0;
   int miscmp  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   cmpact_timer u_cmpact_timer (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .out_a(out_a), .out_b(out_b), .irq(irq)
   );

   task automatic chk(input string req, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         miscmp++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
      wr_reg(lo + 3'd1, v[15:8]);
      wr_reg(lo, v[7:0]);
   endtask

   task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
      logic [7:0] l, h;
      rd_reg(lo, l);
      rd_reg(lo + 3'd1, h);
      v = {h, l};
   endtask

   function automatic logic [7:0] mode_b(input bit run, input bit pin,
                                        input int src, input int ceil);
      return {1'b0, run, pin, 3'(src), 2'(ceil)};
   endfunction

   task automatic pulse(input int k, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ext_tick[k-1] = 1'b1;
         repeat (2) @(negedge clk);
         ext_tick[k-1] = 1'b0;
         repeat (2) @(negedge clk);
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic interval(output int n);
      logic prev;
      int   lim;
      @(negedge clk);
      prev = out_a; lim = 0;
      while (out_a == prev && lim < 5000) begin @(negedge clk); lim++; end
      prev = out_a; n = 0;
      while (n < 5000) begin
         @(negedge clk); n++;
         if (out_a != prev) break;
      end
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         vectors++; miscmp++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
         $finish;
      end
   end

   initial begin
      logic [7:0]  b;
      logic [15:0] w;
      int          n;
      logic        tv;
      int          ys[18];
      logic [15:0] ceils[4];

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      for (int a = 0; a < 8; a++) begin
         rd_reg(3'(a), b);
         chk("R10 reg", b, 0);
      end
      chk("R10 out_a", out_a, 0);
      chk("R10 out_b", out_b, 0);
      chk("R10 irq", irq, 0);

      // R1 period sweep with clear+flip on hit, system clock source
      for (int i = 0; i < 16; i++) ys[i] = i;
      ys[16] = 37; ys[17] = 200;
      wr_reg(3'd0, 8'h03);
      for (int i = 0; i < 18; i++) begin
         wr_reg(3'd1, 8'h00);
         wr16(3'd4, 16'(ys[i]));
         wr16(3'd6, 16'h0000);
         wr_reg(3'd1, mode_b(1, 0, 0, 0));
         interval(n);
         chk($sformatf("R1 period y=%0d", ys[i]), n, ys[i] + 1);
      end
      wr_reg(3'd1, 8'h00);

      // R2 wrap at each ceiling, external source 1
      ceils[0] = 16'hFFFF; ceils[1] = 16'h00FF;
      ceils[2] = 16'h01FF; ceils[3] = 16'h03FF;
      wr_reg(3'd0, 8'h18);
      wr16(3'd4, 16'h7000);
      for (int m = 0; m < 4; m++) begin
         wr_reg(3'd2, 8'h03);
         wr_reg(3'd1, mode_b(1, 0, 1, m));
         wr16(3'd6, ceils[m] - 16'd1);
         tv = out_a;
         pulse(1, 1);
         rd16(3'd6, w);
         chk($sformatf("R2 at ceiling m=%0d", m), w, ceils[m]);
         rd_reg(3'd2, b);
         chk("R2 no flag before wrap", b, 0);
         pulse(1, 1);
         rd16(3'd6, w);
         chk($sformatf("R2 wrap m=%0d", m), w, 0);
         rd_reg(3'd2, b);
         chk("R2 wrap flag", b, 2);
         chk("R2 flip on wrap", out_a, !tv);
      end

      // R9 hit without clear, R3 hit flag
      wr_reg(3'd2, 8'h03);
      wr_reg(3'd1, mode_b(1, 0, 1, 0));
      wr_reg(3'd0, 8'h04);
      wr16(3'd4, 16'd5);
      wr16(3'd6, 16'd3);
      pulse(1, 4);
      rd16(3'd6, w);
      chk("R9 passes compare", w, 7);
      rd_reg(3'd2, b);
      chk("R3 hit flag set", b, 1);

      // R4 masking
      chk("R4 irq masked", irq, 0);
      wr_reg(3'd3, 8'h02);
      @(negedge clk);
      chk("R4 irq other mask", irq, 0);
      wr_reg(3'd3, 8'h01);
      @(negedge clk);
      chk("R4 irq unmasked", irq, 1);
      wr_reg(3'd2, 8'h02);
      rd_reg(3'd2, b);
      chk("R3 write zero keeps flag", b, 1);
      wr_reg(3'd2, 8'h01);
      rd_reg(3'd2, b);
      chk("R3 write one clears", b, 0);
      chk("R4 irq after clear", irq, 0);
      wr_reg(3'd3, 8'h00);

      // R8 unselected sources ignored, selected source counts
      wr_reg(3'd0, 8'h00);
      wr16(3'd6, 16'd10);
      pulse(3, 3);
      pulse(7, 2);
      rd16(3'd6, w);
      chk("R8 unselected ignored", w, 10);
      wr_reg(3'd1, mode_b(1, 0, 3, 0));
      pulse(3, 2);
      rd16(3'd6, w);
      chk("R8 selected counts", w, 12);
      wr_reg(3'd1, mode_b(0, 0, 3, 0));
      pulse(3, 2);
      rd16(3'd6, w);
      chk("R8 run off holds", w, 12);

      // R6 atomic compare write
      wr16(3'd4, 16'h00AB);
      wr_reg(3'd5, 8'h12);
      rd16(3'd4, w);
      chk("R6 high only no commit", w, 16'h00AB);
      wr_reg(3'd5, 8'h12);
      wr_reg(3'd4, 8'h34);
      rd16(3'd4, w);
      chk("R6 commit", w, 16'h1234);

      // R7 read latch
      wr_reg(3'd1, mode_b(1, 0, 1, 0));
      wr16(3'd6, 16'h00FE);
      rd_reg(3'd6, b);
      chk("R7 low byte", b, 8'hFE);
      pulse(1, 3);
      rd_reg(3'd7, b);
      chk("R7 latched high", b, 8'h00);
      rd16(3'd6, w);
      chk("R7 fresh read", w, 16'h0101);

      // R5 pin routing
      wr_reg(3'd1, mode_b(1, 0, 1, 0));
      @(negedge clk);
      tv = out_a;
      wr_reg(3'd1, mode_b(1, 1, 1, 0));
      @(negedge clk);
      chk("R5 out_a low", out_a, 0);
      chk("R5 out_b carries state", out_b, tv);
      wr_reg(3'd0, 8'h02);
      wr16(3'd4, 16'd2);
      wr16(3'd6, 16'd0);
      pulse(1, 3);
      chk("R5 out_b flipped", out_b, !tv);
      chk("R5 out_a stays low", out_a, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   end

endmodule